// File: doc/BRIEF.md
# DDR2 Bank Precharge and Activate Timing Monitor

This block sits passively on a DDR2-style command bus serving four banks. On every rising clock edge it decodes the command pins. It keeps an open or closed flag for each bank. It also keeps three saturating clock counters for each bank, measuring the distance since that bank's last read, last activate and last precharge.

When a precharge or an activate arrives before the relevant timing interval has elapsed, the monitor raises a one-cycle violation pulse. The pulse carries a rule code and the number of the offending bank. The command is still applied to the bank state, so later checks follow what the memory actually saw.

The read-to-precharge minimum depends on several inputs: the additive latency, half the burst length, and one extra clock when the internal read-to-precharge delay is longer than two clocks. All timing values are static configuration inputs given in clocks.

Top module: `ddr_bank_timing_mon`

## Requirements
- R1: The command pins are sampled as {cs_n, ras_n, cas_n, we_n}. Precharge is 0010, activate is 0011 and read is 0101. Any other pattern, including write (0100) and any cycle with cs_n high, changes no bank state and raises no violation.
- R2: A precharge with a10_i high targets all four banks, and ba_i is ignored. After it, every bank is closed.
- R3: A precharge with a10_i low targets only the bank given by ba_i: 00 is bank 0, 01 bank 1, 10 bank 2 and 11 bank 3. An activate selects its bank with the same mapping and opens it.
- R4: When trtp_i is 2 or less, a precharge to an open bank N clocks after its last read is a violation with rule 0 if N < al_i + BL/2. Here BL is 8 when bl8_i is 1 and 4 otherwise.
- R5: When trtp_i is greater than 2, the read-to-precharge minimum of R4 grows by one clock.
- R6: A precharge to an open bank fewer than tras_i clocks after its activate is a violation with rule 1.
- R7: An activate is a violation with rule 2 if fewer than trp_i clocks have passed since that bank's last precharge. Otherwise it is a violation with rule 3 if fewer than trc_i clocks have passed since that bank's last activate. Both intervals must be met for a clean activate.
- R8: viol_o is high for exactly the cycle after the offending command's clock edge. When several banks are at fault, the lowest-numbered bank is reported. Within one bank the rules take priority in the order 0, 1, 2, 3.
- R9: A precharge to a closed bank never raises a violation, but it restarts that bank's tRP interval.
- R10: After reset all banks are closed, every interval is treated as already met, and viol_o is low.
- R11: The per-bank counters saturate at their maximum (63 clocks by default) instead of wrapping, so a long idle gap never produces a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | All-banks select for precharge |
| al_i | input | 3 | Additive latency, 0 to 4 clocks |
| bl8_i | input | 1 | 1 selects burst length 8, 0 selects 4 |
| trtp_i | input | TW | Internal read-to-precharge delay in clocks |
| tras_i | input | TW | Minimum activate-to-precharge interval |
| trp_i | input | TW | Minimum precharge-to-activate interval |
| trc_i | input | TW | Minimum activate-to-activate interval |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_rule_o | output | 2 | 0 read-to-precharge, 1 tRAS, 2 tRP, 3 tRC |
| viol_bank_o | output | 2 | Bank at fault |

## Verification
The hardest situations to reach are those where two intervals interact. One is an activate whose tRP is met but whose tRC is not, which needs a precharge placed inside the tRC window. The other is an all-banks precharge that hits several open banks at different ages. The stimulus sweeps the activate-to-precharge and precharge-to-activate spacings over a full grid, so every combination of rule 2, rule 3 and a clean activate occurs. It also opens two banks one clock apart before a single all-banks precharge. The counter saturation case is reached by holding a bank idle for longer than the counter range, with tRAS set to its maximum.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BA_W      = 2;

  typedef enum logic [1:0] {
    RULE_RTP = 2'd0,
    RULE_RAS = 2'd1,
    RULE_RP  = 2'd2,
    RULE_RC  = 2'd3
  } rule_e;

  typedef struct packed {
    logic            act;
    logic            rd;
    logic            pre;
    logic            all;
    logic [BA_W-1:0] bank;
  } cmd_t;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic            cs_n_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output cmd_t            cmd_o
);
  always_comb begin
    cmd_o.pre  = !cs_n_i && !ras_n_i &&  cas_n_i && !we_n_i;
    cmd_o.act  = !cs_n_i && !ras_n_i &&  cas_n_i &&  we_n_i;
    cmd_o.rd   = !cs_n_i &&  ras_n_i && !cas_n_i &&  we_n_i;
    cmd_o.all  = a10_i;
    cmd_o.bank = ba_i;
  end
endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic [TW-1:0] rtp_req_i,
  input  logic [TW-1:0] tras_i,
  input  logic [TW-1:0] trp_i,
  input  logic [TW-1:0] trc_i,
  output logic          open_o,
  output logic [3:0]    bad_o     // bit index = rule code
);
  localparam logic [TW-1:0] SAT = '1;
  localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

  logic          open_q;
  logic [TW-1:0] rd_cnt_q, act_cnt_q, pre_cnt_q;

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] c);
    return (c == SAT) ? c : c + ONE;
  endfunction

  // counter value = clocks since the event, seen at the checking edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      rd_cnt_q  <= SAT;
      act_cnt_q <= SAT;
      pre_cnt_q <= SAT;
    end else begin
      if (act_i)      open_q <= 1'b1;
      else if (pre_i) open_q <= 1'b0;
      rd_cnt_q  <= rd_i  ? ONE : bump(rd_cnt_q);
      act_cnt_q <= act_i ? ONE : bump(act_cnt_q);
      pre_cnt_q <= pre_i ? ONE : bump(pre_cnt_q);
    end
  end

  assign open_o   = open_q;
  assign bad_o[0] = pre_i && open_q && (rd_cnt_q  < rtp_req_i);
  assign bad_o[1] = pre_i && open_q && (act_cnt_q < tras_i);
  assign bad_o[2] = act_i && (pre_cnt_q < trp_i);
  assign bad_o[3] = act_i && (act_cnt_q < trc_i);
endmodule

// File: rtl/ddr_viol_arbiter.sv
module ddr_viol_arbiter
  import ddr_mon_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  logic [NB-1:0][3:0] bad_i,
  output logic               hit_o,
  output rule_e              rule_o,
  output logic [BA_W-1:0]    bank_o
);
  always_comb begin
    hit_o  = 1'b0;
    rule_o = RULE_RTP;
    bank_o = '0;
    // descending scan: lowest faulty bank ends up winning
    for (int b = NB - 1; b >= 0; b--) begin
      if (|bad_i[b]) begin
        hit_o  = 1'b1;
        bank_o = BA_W'(b);
        if (bad_i[b][0])      rule_o = RULE_RTP;
        else if (bad_i[b][1]) rule_o = RULE_RAS;
        else if (bad_i[b][2]) rule_o = RULE_RP;
        else                  rule_o = RULE_RC;
      end
    end
  end
endmodule

// File: rtl/ddr_bank_timing_mon.sv
module ddr_bank_timing_mon
  import ddr_mon_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_i,
  input  logic          ras_n_i,
  input  logic          cas_n_i,
  input  logic          we_n_i,
  input  logic [1:0]    ba_i,
  input  logic          a10_i,
  input  logic [2:0]    al_i,
  input  logic          bl8_i,
  input  logic [TW-1:0] trtp_i,
  input  logic [TW-1:0] tras_i,
  input  logic [TW-1:0] trp_i,
  input  logic [TW-1:0] trc_i,
  output logic          viol_o,
  output logic [1:0]    viol_rule_o,
  output logic [1:0]    viol_bank_o
);
  localparam int            NB        = NUM_BANKS;
  localparam logic [TW-1:0] ONE       = {{(TW-1){1'b0}}, 1'b1};
  localparam logic [TW-1:0] HALF_BL4  = ONE + ONE;
  localparam logic [TW-1:0] HALF_BL8  = HALF_BL4 + HALF_BL4;
  localparam logic [TW-1:0] TRTP_FAST = HALF_BL4;

  cmd_t                cmd;
  logic [TW-1:0]       rtp_req;
  logic [NB-1:0]       bank_open;
  logic [NB-1:0][3:0]  bad;
  logic                hit;
  rule_e               rule;
  logic [BA_W-1:0]     bank;

  ddr_cmd_decode u_dec (
    .cs_n_i (cs_n_i),
    .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i),
    .we_n_i (we_n_i),
    .ba_i   (ba_i),
    .a10_i  (a10_i),
    .cmd_o  (cmd)
  );

  always_comb begin
    rtp_req = {{(TW-3){1'b0}}, al_i};
    rtp_req = rtp_req + (bl8_i ? HALF_BL8 : HALF_BL4);
    if (trtp_i > TRTP_FAST) rtp_req = rtp_req + ONE;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = (cmd.bank == BA_W'(b));
    ddr_bank_timer #(.TW(TW)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_i     (cmd.rd  && sel),
      .act_i    (cmd.act && sel),
      .pre_i    (cmd.pre && (cmd.all || sel)),
      .rtp_req_i(rtp_req),
      .tras_i   (tras_i),
      .trp_i    (trp_i),
      .trc_i    (trc_i),
      .open_o   (bank_open[b]),
      .bad_o    (bad[b])
    );
  end

  ddr_viol_arbiter #(.NB(NB)) u_arb (
    .bad_i (bad),
    .hit_o (hit),
    .rule_o(rule),
    .bank_o(bank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_rule_o <= 2'd0;
      viol_bank_o <= 2'd0;
    end else begin
      viol_o      <= hit;
      viol_rule_o <= rule;
      viol_bank_o <= bank;
    end
  end
endmodule

// File: rtl/ddr_bank_timing_mon_chk.sv
module ddr_bank_timing_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_i,
  input logic       ras_n_i,
  input logic       cas_n_i,
  input logic       we_n_i,
  input logic [1:0] ba_i,
  input logic       a10_i,
  input logic       viol_o,
  input logic [1:0] viol_rule_o,
  input logic [3:0] bank_open
);
  logic is_pre, is_act;
  assign is_pre = !cs_n_i && !ras_n_i && cas_n_i && !we_n_i;
  assign is_act = !cs_n_i && !ras_n_i && cas_n_i &&  we_n_i;

  assert_deselect_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !viol_o);

  assert_pre_all_closes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre && a10_i) |=> (bank_open == 4'b0000));

  assert_act_opens_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |=> bank_open[$past(ba_i)]);

  assert_pre_rules_from_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !viol_rule_o[1]) |-> $past(is_pre));

  assert_act_rules_from_act_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && viol_rule_o[1]) |-> $past(is_act));

  assert_viol_follows_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(is_pre || is_act));

  assert_closed_pre_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre && bank_open == 4'b0000) |=> !viol_o);
endmodule

bind ddr_bank_timing_mon ddr_bank_timing_mon_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .ras_n_i    (ras_n_i),
  .cas_n_i    (cas_n_i),
  .we_n_i     (we_n_i),
  .ba_i       (ba_i),
  .a10_i      (a10_i),
  .viol_o     (viol_o),
  .viol_rule_o(viol_rule_o),
  .bank_open  (bank_open)
);

// File: tb/ddr_bank_timing_mon_tb.sv
`timescale 1ns/1ps
module ddr_bank_timing_mon_tb;
  localparam int TW = 6;
  localparam logic [3:0] C_PRE = 4'b0010, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR  = 4'b0100, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [2:0] al;
  logic bl8;
  logic [TW-1:0] trtp, tras, trp, trc;
  logic viol;
  logic [1:0] rule, bank;
  int vecs = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddr_bank_timing_mon #(.TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .ba_i(ba), .a10_i(a10), .al_i(al), .bl8_i(bl8), .trtp_i(trtp),
    .tras_i(tras), .trp_i(trp), .trc_i(trc), .viol_o(viol), .viol_rule_o(rule),
    .viol_bank_o(bank)
  );

  // drive for one edge, then return to NOP; returns at posedge+1
  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic all);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; a10 = all;
    @(posedge clk); #1;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    a10 = 1'b0;
  endtask

  task automatic nop(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_v(input logic ev, input logic [1:0] er, input logic [1:0] eb,
                          input string tag);
    vecs++;
    if (viol !== ev || (ev && (rule !== er || bank !== eb))) begin
      fails++;
      $display("FAIL %s: got viol=%0b rule=%0d bank=%0d, want viol=%0b rule=%0d bank=%0d",
               tag, viol, rule, bank, ev, er, eb);
    end
  endtask

  initial begin
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    ba = 2'd0; a10 = 1'b0;
    al = 3'd0; bl8 = 1'b0; trtp = 6'd2; tras = 6'd1; trp = 6'd20; trc = 6'd20;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    expect_v(1'b0, 2'd0, 2'd0, "R10 reset");
    // R10: timers satisfied after reset
    drive(C_ACT, 2'd0, 1'b0); expect_v(1'b0, 2'd0, 2'd0, "R10 first act");
    drive(C_PRE, 2'd1, 1'b0); expect_v(1'b0, 2'd0, 2'd0, "R10 pre closed");
    nop(4); drive(C_PRE, 2'd0, 1'b0); expect_v(1'b0, 2'd0, 2'd0, "R10 close");
    trp = 6'd1; trc = 6'd1;

    // R4 / R5: read-to-precharge sweep
    for (int a = 0; a <= 4; a++)
      for (int b8 = 0; b8 < 2; b8++)
        for (int tr = 2; tr <= 3; tr++) begin
          int req;
          al = 3'(a); bl8 = b8[0]; trtp = 6'(tr);
          req = a + (b8 ? 4 : 2) + (tr > 2 ? 1 : 0);
          for (int g = 1; g <= req + 1; g++) begin
            logic [1:0] bk;
            bk = 2'(g % 4);
            nop(12);
            drive(C_ACT, bk, 1'b0);
            drive(C_RD, bk, 1'b0);
            if (g > 1) nop(g - 1);
            drive(C_PRE, bk, 1'b0);
            expect_v(g < req, 2'd0, bk, tr > 2 ? "R5 rtp+1" : "R4 rtp");
            nop(1);
            expect_v(1'b0, 2'd0, 2'd0, "R8 pulse width");
          end
        end
    al = 3'd0; bl8 = 1'b0; trtp = 6'd2;

    // R6: tRAS sweep
    tras = 6'd5;
    for (int g = 1; g <= 7; g++) begin
      nop(12);
      drive(C_ACT, 2'(g % 4), 1'b0);
      if (g > 1) nop(g - 1);
      drive(C_PRE, 2'(g % 4), 1'b0);
      expect_v(g < 5, 2'd1, 2'(g % 4), "R6 tras");
    end

    // R7: tRP / tRC grid
    tras = 6'd1; trp = 6'd3; trc = 6'd6;
    for (int p = 1; p <= 6; p++)
      for (int q = 1; q <= 6; q++) begin
        logic [1:0] bk;
        bk = 2'((p + q) % 4);
        nop(12);
        drive(C_ACT, bk, 1'b0);
        if (p > 1) nop(p - 1);
        drive(C_PRE, bk, 1'b0);
        if (q > 1) nop(q - 1);
        drive(C_ACT, bk, 1'b0);
        expect_v(q < 3 || p + q < 6, (q < 3) ? 2'd2 : 2'd3, bk, "R7 rp/rc");
        nop(1);
        drive(C_PRE, bk, 1'b0);
      end
    trp = 6'd1; trc = 6'd1;

    // R2 / R8 / R9: all-banks precharge, priority, closed precharge
    tras = 6'd4; trp = 6'd3;
    nop(12);
    drive(C_ACT, 2'd2, 1'b0);
    drive(C_ACT, 2'd0, 1'b0);
    drive(C_PRE, 2'd3, 1'b1);
    expect_v(1'b1, 2'd1, 2'd0, "R2 R8 all-bank lowest");
    drive(C_PRE, 2'd1, 1'b1);
    expect_v(1'b0, 2'd0, 2'd0, "R9 all closed");
    drive(C_ACT, 2'd1, 1'b0);
    expect_v(1'b1, 2'd2, 2'd1, "R9 trp restart");
    nop(12); drive(C_PRE, 2'd1, 1'b0);
    trp = 6'd1;

    // R3: bank address mapping
    for (int b = 0; b < 4; b++) begin
      nop(12);
      drive(C_ACT, 2'(b), 1'b0);
      drive(C_PRE, 2'(b) ^ 2'd1, 1'b0);
      expect_v(1'b0, 2'd0, 2'd0, "R3 other bank");
      drive(C_PRE, 2'(b), 1'b0);
      expect_v(1'b1, 2'd1, 2'(b), "R3 selected bank");
    end

    // R1: write and deselected patterns are ignored
    tras = 6'd1;
    nop(12);
    drive(C_ACT, 2'd3, 1'b0);
    nop(12);
    drive(C_WR, 2'd3, 1'b0);
    drive(C_PRE, 2'd3, 1'b0);
    expect_v(1'b0, 2'd0, 2'd0, "R1 write not read");
    tras = 6'd20;
    nop(12);
    drive(C_ACT, 2'd1, 1'b0);
    drive(4'b1010, 2'd1, 1'b0);
    expect_v(1'b0, 2'd0, 2'd0, "R1 deselect");
    drive(C_PRE, 2'd1, 1'b0);
    expect_v(1'b1, 2'd1, 2'd1, "R1 bank still open");

    // R11: saturation
    tras = 6'd63; trc = 6'd63;
    nop(12);
    drive(C_ACT, 2'd2, 1'b0);
    nop(69);
    drive(C_PRE, 2'd2, 1'b0);
    expect_v(1'b0, 2'd0, 2'd0, "R11 tras sat");
    drive(C_ACT, 2'd2, 1'b0);
    expect_v(1'b0, 2'd0, 2'd0, "R11 trc sat");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule